// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block is a bank of 32-bit control registers inside a byte-addressed window. A small plain bank sits at the bottom of the window. An aliased bank sits higher up, behind a base offset. Each aliased register owns four consecutive words:

- The base word replaces the register on a write.
- The next three words change the same storage in one cycle. A write to the first ORs the data in, a write to the second clears the bits named in the data, and a write to the third inverts them.

A read from any of the four words returns the base register. Every register drives a parallel output, so the logic downstream sees the current control value without a bus read.

The bus has separate write and read channels, and each channel carries its own byte size. The response side is a three-state machine:

- **ST_IDLE**: no read response.
- **ST_RD_OK**: read data is valid.
- **ST_RD_BAD**: a rejected read. It returns zero and raises the error flag.

Each cycle the machine takes one of three transitions:

- **IDLE_NEXT**: no read is requested, so the next state is ST_IDLE.
- **GOOD_READ**: a read arrives with a valid size and alignment, so the next state is ST_RD_OK.
- **BAD_READ**: a read arrives with a bad size or alignment, so the next state is ST_RD_BAD.

The transition is taken from any state. A rejected write raises the same error flag one cycle later.

Top module: `stc_reg_bank`

## Requirements
- R1: After reset, each register holds its reset value. Each aliased register flagged as a PLL control register also has its lock bit (bit 31) set. With the default parameters, the aliased registers 0..3 read 0x80001100, 0x80002001, 0x00402010 and 0x00000F74, and the plain registers 0..3 read 0x12340000, 0x00005A5A, 0x00000079 and 0xFFFFFFFF.
- R2: A write to an aliased base word replaces the whole register. Aliased register g has its base at byte 0x4000 + 16*g.
- R3: A write to base+4 (the SET alias) ORs the write data into the register.
- R4: A write to base+8 (the CLR alias) ANDs the register with the inverse of the write data.
- R5: A write to base+12 (the TOG alias) XORs the write data into the register.
- R6: A read from the base word or from any of its three aliases returns the register's current value.
- R7: Plain register p sits at byte 4*p. A write to it replaces the whole register.
- R8: Every read is answered exactly one cycle later by a one-cycle rd_valid pulse carrying the data. When no read was issued, rd_valid stays low.
- R9: An access is rejected if its size is not 4 bytes or its address bits [1:0] are not zero. A rejected write changes nothing. A rejected read returns zero. In both cases acc_err pulses for one cycle, one cycle after the access.
- R10: A read and a write to the same register in the same cycle return the value from before the write. The next read sees the new value.
- R11: An aligned 4-byte access to an address outside both banks raises no error. If it is a write it changes nothing, and if it is a read it returns zero.
- R12: The parallel outputs show every register's new value in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 15 | Write byte address within the window |
| wr_size | input | 3 | Write size in bytes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 15 | Read byte address within the window |
| rd_size | input | 3 | Read size in bytes |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| acc_err | output | 1 | One-cycle pulse for a rejected access |
| plain_regs_o | output | 128 | Plain registers, register p at bits [32p+31:32p] |
| alias_regs_o | output | 128 | Aliased registers, register g at bits [32g+31:32g] |

## Verification
A write and a read can land in the same cycle, on the same register or through different aliases of it. In that case the read must return the value from before the write, while the parallel output already shows the result of the write. The bench provokes this in two ways:

- Directed cases pair a SET, CLR or TOG write with a read of a sibling alias.
- Random traffic issues both channels in most cycles over a small address set, so collisions happen often.

A bench model captures the expected read value before it applies the write. It then compares the read response and every parallel output against that model.

// File: rtl/stc_bank_pkg.sv
`timescale 1ns/1ps
package stc_bank_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } bank_op_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_PLAIN = 2'd1,
        TGT_ALIAS = 2'd2
    } bank_tgt_e;

    typedef struct packed {
        bank_tgt_e        tgt;
        logic [IDX_W-1:0] idx;
        bank_op_e         op;
        logic             fault;
    } bank_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_OK  = 2'd1,
        ST_RD_BAD = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/stc_addr_decode.sv
`timescale 1ns/1ps
module stc_addr_decode
    import stc_bank_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int NUM_PLAIN    = 4,
    parameter int NUM_ALIAS    = 4,
    parameter int ALIAS_OFFSET = 32'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output bank_dec_t         dec
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int ALIAS_W0  = ALIAS_OFFSET / 4;
    localparam int ALIAS_WE  = ALIAS_W0 + 4 * NUM_ALIAS;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rel;

    always_comb begin
        word      = addr[ADDR_W-1:2];
        rel       = word - WORD_W'(ALIAS_W0);
        dec.fault = (size != 3'd4) || (addr[1:0] != 2'b00);
        dec.tgt   = TGT_NONE;
        dec.idx   = '0;
        dec.op    = OP_WRITE;
        if (word < WORD_W'(NUM_PLAIN)) begin
            dec.tgt = TGT_PLAIN;
            dec.idx = IDX_W'(word);
        end else if (word >= WORD_W'(ALIAS_W0) && word < WORD_W'(ALIAS_WE)) begin
            dec.tgt = TGT_ALIAS;
            dec.idx = IDX_W'(rel >> 2);
            dec.op  = bank_op_e'(rel[1:0]);
        end
    end
endmodule

// File: rtl/stc_bank_reg.sv
`timescale 1ns/1ps
module stc_bank_reg
    import stc_bank_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  bank_op_e          op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (we) begin
            unique case (op)
                OP_WRITE: nxt = wdata;
                OP_SET:   nxt = q | wdata;
                OP_CLR:   nxt = q & ~wdata;
                OP_TOG:   nxt = q ^ wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
    end

    // R2
    plain_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_WRITE) |=> q == $past(wdata));
    // R3
    set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_SET) |=> (q & $past(wdata)) == $past(wdata));
    // R4
    clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLR) |=> (q & $past(wdata)) == '0);
    // R5
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_TOG) |=> (q ^ $past(q)) == $past(wdata));
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/stc_reg_bank.sv
`timescale 1ns/1ps
module stc_reg_bank
    import stc_bank_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int NUM_PLAIN    = 4,
    parameter int NUM_ALIAS    = 4,
    parameter int ALIAS_OFFSET = 32'h4000,
    parameter int LOCK_BIT     = 31,
    parameter logic [NUM_ALIAS-1:0] LOCK_MASK = 4'b0011,
    parameter logic [NUM_ALIAS-1:0][DATA_W-1:0] ALIAS_RST =
        {32'h0000_0F74, 32'h0040_2010, 32'h0000_2001, 32'h0000_1100},
    parameter logic [NUM_PLAIN-1:0][DATA_W-1:0] PLAIN_RST =
        {32'hFFFF_FFFF, 32'h0000_0079, 32'h0000_5A5A, 32'h1234_0000}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [2:0]                    wr_size,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [2:0]                    rd_size,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          acc_err,
    output logic [NUM_PLAIN*DATA_W-1:0]   plain_regs_o,
    output logic [NUM_ALIAS*DATA_W-1:0]   alias_regs_o
);
    localparam logic [DATA_W-1:0] LOCK_VAL = DATA_W'(1) << LOCK_BIT;

    bank_dec_t  wr_dec, rd_dec;
    rsp_state_e state_q, state_d;
    logic [DATA_W-1:0] rd_sel, rd_hold_q;
    logic              wr_fault_q;
    logic              wr_ok, rd_bad;

    logic [DATA_W-1:0] plain_q [NUM_PLAIN];
    logic [DATA_W-1:0] alias_q [NUM_ALIAS];

    stc_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_PLAIN(NUM_PLAIN),
        .NUM_ALIAS(NUM_ALIAS), .ALIAS_OFFSET(ALIAS_OFFSET)
    ) wr_dec_i (.addr(wr_addr), .size(wr_size), .dec(wr_dec));

    stc_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_PLAIN(NUM_PLAIN),
        .NUM_ALIAS(NUM_ALIAS), .ALIAS_OFFSET(ALIAS_OFFSET)
    ) rd_dec_i (.addr(rd_addr), .size(rd_size), .dec(rd_dec));

    assign wr_ok  = wr_en && !wr_dec.fault;
    assign rd_bad = rd_en && rd_dec.fault;

    generate
        for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
            logic p_we;
            assign p_we = wr_ok && wr_dec.tgt == TGT_PLAIN && wr_dec.idx == IDX_W'(p);
            stc_bank_reg #(.RST_VAL(PLAIN_RST[p])) reg_i (
                .clk(clk), .rst_n(rst_n), .we(p_we), .op(OP_WRITE),
                .wdata(wr_data), .q(plain_q[p]));
            assign plain_regs_o[p*DATA_W +: DATA_W] = plain_q[p];
        end
        for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
            localparam logic [DATA_W-1:0] RV =
                ALIAS_RST[g] | (LOCK_MASK[g] ? LOCK_VAL : '0);
            logic a_we;
            assign a_we = wr_ok && wr_dec.tgt == TGT_ALIAS && wr_dec.idx == IDX_W'(g);
            stc_bank_reg #(.RST_VAL(RV)) reg_i (
                .clk(clk), .rst_n(rst_n), .we(a_we), .op(wr_dec.op),
                .wdata(wr_data), .q(alias_q[g]));
            assign alias_regs_o[g*DATA_W +: DATA_W] = alias_q[g];
        end
    endgenerate

    // Read select uses the storage before this cycle's write lands.
    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NUM_PLAIN; p++)
            if (rd_dec.tgt == TGT_PLAIN && rd_dec.idx == IDX_W'(p)) rd_sel = plain_q[p];
        for (int g = 0; g < NUM_ALIAS; g++)
            if (rd_dec.tgt == TGT_ALIAS && rd_dec.idx == IDX_W'(g)) rd_sel = alias_q[g];
    end

    // Next-state logic
    always_comb begin
        if (!rd_en)      state_d = ST_IDLE;
        else if (rd_bad) state_d = ST_RD_BAD;
        else             state_d = ST_RD_OK;
    end

    // State register and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_hold_q  <= '0;
            wr_fault_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            rd_hold_q  <= (rd_en && !rd_bad) ? rd_sel : '0;
            wr_fault_q <= wr_en && wr_dec.fault;
        end
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        acc_err  = wr_fault_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RD_OK:  begin rd_valid = 1'b1; rd_data = rd_hold_q; end
            ST_RD_BAD: begin rd_valid = 1'b1; acc_err = 1'b1; end
            default:   ;
        endcase
    end

    // R8
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R8
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R9
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_dec.fault) |=> (acc_err && rd_data == '0));
    // R9
    bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dec.fault) |=> acc_err);
    // R11
    clean_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && rd_dec.fault) && !(wr_en && wr_dec.fault)) |=> !acc_err);
    // R10
    read_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_dec.fault && rd_dec.tgt == TGT_ALIAS && wr_ok
         && wr_dec.tgt == TGT_ALIAS && wr_dec.idx == rd_dec.idx)
        |=> rd_data == $past(alias_regs_o[rd_dec.idx[1:0]*DATA_W +: DATA_W]));
endmodule

// File: tb/stc_reg_bank_tb.sv
`timescale 1ns/1ps
module stc_reg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [14:0] wr_addr = '0, rd_addr = '0;
    logic [2:0]  wr_size = 3'd4, rd_size = 3'd4;
    logic [31:0] wr_data = '0;
    logic        rd_valid, acc_err;
    logic [31:0] rd_data;
    logic [127:0] plain_regs_o, alias_regs_o;

    int n_tests = 0, n_fail = 0;
    logic [31:0] am [4];
    logic [31:0] pm [4];

    always #5 clk = ~clk;

    stc_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .plain_regs_o(plain_regs_o), .alias_regs_o(alias_regs_o));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic bit acc_good(input logic [14:0] a, input logic [2:0] s);
        return (s == 3'd4) && (a[1:0] == 2'b00);
    endfunction

    // 0 none, 1 plain, 2 aliased
    function automatic int region(input logic [14:0] a);
        if (a < 15'h10) return 1;
        if (a >= 15'h4000 && a < 15'h4040) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [14:0] a, input logic [2:0] s);
        if (!acc_good(a, s)) return 32'h0;
        case (region(a))
            1: return pm[a[3:2]];
            2: return am[a[5:4]];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [14:0] a, input logic [2:0] s, input logic [31:0] d);
        if (!acc_good(a, s)) return;
        case (region(a))
            1: pm[a[3:2]] = d;
            2: case (a[3:2])
                   2'd0: am[a[5:4]] = d;
                   2'd1: am[a[5:4]] = am[a[5:4]] | d;
                   2'd2: am[a[5:4]] = am[a[5:4]] & ~d;
                   default: am[a[5:4]] = am[a[5:4]] ^ d;
               endcase
            default: ;
        endcase
    endtask

    task automatic check_outputs(input string req);
        for (int i = 0; i < 4; i++) begin
            chk(alias_regs_o[i*32 +: 32] === am[i], req, alias_regs_o[i*32 +: 32], am[i]);
            chk(plain_regs_o[i*32 +: 32] === pm[i], req, plain_regs_o[i*32 +: 32], pm[i]);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic access(input bit we, input logic [14:0] wa, input logic [2:0] ws, input logic [31:0] wd,
                          input bit re, input logic [14:0] ra, input logic [2:0] rs, input string req);
        logic [31:0] exp_rd;
        bit exp_err;
        exp_rd  = model_read(ra, rs);
        exp_err = (we && !acc_good(wa, ws)) || (re && !acc_good(ra, rs));
        wr_en = we; wr_addr = wa; wr_size = ws; wr_data = wd;
        rd_en = re; rd_addr = ra; rd_size = rs;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_valid === re, {req, " rd_valid"}, 32'(rd_valid), 32'(re));
        if (re) chk(rd_data === exp_rd, {req, " rd_data"}, rd_data, exp_rd);
        chk(acc_err === exp_err, {req, " acc_err"}, 32'(acc_err), 32'(exp_err));
        if (we) model_write(wa, ws, wd);
        check_outputs({req, " outputs (R12)"});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1357);
        am[0] = 32'h8000_1100; am[1] = 32'h8000_2001;
        am[2] = 32'h0040_2010; am[3] = 32'h0000_0F74;
        pm[0] = 32'h1234_0000; pm[1] = 32'h0000_5A5A;
        pm[2] = 32'h0000_0079; pm[3] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state with lock bits
        check_outputs("R1 reset");
        chk(rd_valid === 1'b0 && acc_err === 1'b0, "R1 idle flags", {30'b0, rd_valid, acc_err}, 32'h0);
        // R6 every alias reads the base register
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < 4; k++)
                access(1'b0, '0, 3'd4, '0, 1'b1, 15'(16'h4000 + 16*g + 4*k), 3'd4, "R6 alias read");
        // R2 base replace
        access(1'b1, 15'h4010, 3'd4, 32'hDEAD_BEEF, 1'b1, 15'h4010, 3'd4, "R2 base write");
        access(1'b0, '0, 3'd4, '0, 1'b1, 15'h4018, 3'd4, "R2 readback");
        // R3 / R4 / R5
        access(1'b1, 15'h4004, 3'd4, 32'h0F00_00F0, 1'b0, '0, 3'd4, "R3 set");
        access(1'b1, 15'h4008, 3'd4, 32'h8000_0100, 1'b0, '0, 3'd4, "R4 clr");
        access(1'b1, 15'h400C, 3'd4, 32'hFFFF_0000, 1'b1, 15'h4000, 3'd4, "R5 tog");
        // R10 same-cycle write and read through sibling aliases
        access(1'b1, 15'h4034, 3'd4, 32'h0000_F000, 1'b1, 15'h403C, 3'd4, "R10 set+read");
        access(1'b1, 15'h403C, 3'd4, 32'hAAAA_5555, 1'b1, 15'h4030, 3'd4, "R10 tog+read");
        access(1'b0, '0, 3'd4, '0, 1'b1, 15'h4038, 3'd4, "R10 new value");
        // R7 plain bank
        access(1'b1, 15'h0008, 3'd4, 32'hC0FF_EE00, 1'b1, 15'h0008, 3'd4, "R7 plain write");
        access(1'b0, '0, 3'd4, '0, 1'b1, 15'h0008, 3'd4, "R7 readback");
        // R9 rejected accesses
        access(1'b1, 15'h4004, 3'd2, 32'hFFFF_FFFF, 1'b0, '0, 3'd4, "R9 bad size write");
        access(1'b1, 15'h0006, 3'd4, 32'h1111_1111, 1'b0, '0, 3'd4, "R9 unaligned write");
        access(1'b0, '0, 3'd4, '0, 1'b1, 15'h4002, 3'd4, "R9 unaligned read");
        access(1'b0, '0, 3'd4, '0, 1'b1, 15'h0000, 3'd1, "R9 bad size read");
        // R11 unmapped
        access(1'b1, 15'h2000, 3'd4, 32'h7777_7777, 1'b1, 15'h2000, 3'd4, "R11 unmapped");
        access(1'b1, 15'h4040, 3'd4, 32'h7777_7777, 1'b1, 15'h4044, 3'd4, "R11 past bank");
        // R8 no read, no response
        access(1'b0, '0, 3'd4, '0, 1'b0, '0, 3'd4, "R8 idle");
        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [14:0] wa, ra;
            logic [2:0]  ws, rs;
            wa = ($urandom % 3 == 0) ? 15'(4 * ($urandom % 4)) : 15'(16'h4000 + 4 * ($urandom % 16));
            ra = ($urandom % 3 == 0) ? 15'(4 * ($urandom % 4)) : 15'(16'h4000 + 4 * ($urandom % 16));
            if ($urandom % 10 == 0) wa = wa + 15'($urandom % 4);
            if ($urandom % 10 == 0) ra = ra + 15'($urandom % 4);
            ws = ($urandom % 12 == 0) ? 3'(1 + $urandom % 3) : 3'd4;
            rs = ($urandom % 12 == 0) ? 3'(1 + $urandom % 3) : 3'd4;
            access(1'($urandom % 4 != 0), wa, ws, $urandom, 1'($urandom % 4 != 0), ra, rs,
                   "R3 R4 R5 R10 random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule